// File: doc/BRIEF.md
# Program Address Unit with Circular Return Stack

This unit holds the instruction address of a small 4-bit processor with a 12-bit address space. It keeps four 12-bit address registers in a ring. A 2-bit pointer selects one of them as the live program counter, and the other three hold return addresses. The unit applies one operation per clock: step the address, call a subroutine, return, jump within a page, or jump to any address. An operation code that is not in use leaves all state alone.

A call stores the address after the call in the current slot, moves the pointer forward, and loads the target into the new slot. A return moves the pointer back. The ring has no guard against overflow or underflow. Three nested calls fit. A fourth call reuses the slot that held the first return address. Popping past the bottom wraps to the top slot and raises no flag. A page jump takes its high nibble from the address after the jump instruction, so a jump placed on byte 0xFF of a page lands in the next page.

The surrounding processor fetches instructions and evaluates jump conditions. It presents only the decoded operation and its operand.

Top module: `pcu_top`

## Requirements
- R1: While reset is active, and after reset is released, the program counter reads 0, the pointer is 0 and every slot holds 0. A return issued straight after reset therefore gives 0.
- R2: Operation code 1 (step) advances the program counter by one, modulo 4096, so 0xFFF becomes 0x000.
- R3: Operation code 2 (call) makes the program counter equal to the 12-bit target in the next cycle. It saves the old program counter plus one as the return address.
- R4: Operation code 3 (return) restores the return address saved by the matching call, through three nested levels.
- R5: A fourth nested call overwrites the first saved return address. The fourth return after it yields the fourth call's target instead of the first return address.
- R6: Operation code 4 (page jump) loads {(PC+1)[11:8], target[7:0]}. Taken from byte 0xFF of a page, it goes to the next page, and from 0xFFF it goes to page 0.
- R7: Operation code 5 (jump) loads all 12 target bits.
- R8: Returns past the bottom of the ring wrap the pointer modulo 4 and raise no flag.
- R9: Operation codes 0, 6 and 7 change neither the program counter nor any saved address or the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_i | input | 3 | Operation: 0 hold, 1 step, 2 call, 3 return, 4 page jump, 5 jump, 6/7 hold |
| tgt_i | input | 12 | Call or jump target. A page jump uses bits 7:0 only |
| pc_o | output | 12 | Current program counter |

## Verification
Page jumps are swept over all sixteen pages, once from byte 0xFF and once from the middle of the page. This separates resolving against the incremented address from resolving against the jump's own page, including the wrap from page 15 to page 0. Stepping across 0xFFF checks the counter wrap. Nested calls to three levels, and then to four, separate a correct return chain from one that loses or overwrites the wrong slot. Extra returns show whether the pointer wraps silently. Unused operation codes are followed by returns, which show through pc_o that the saved addresses stayed intact.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [2:0] {
    PCU_HOLD = 3'd0,
    PCU_STEP = 3'd1,
    PCU_CALL = 3'd2,
    PCU_RET  = 3'd3,
    PCU_PJMP = 3'd4,
    PCU_JMP  = 3'd5
  } pcu_op_e;
endpackage

// File: rtl/pcu_rst_sync.sv
module pcu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pcu_ptr.sv
module pcu_ptr #(
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] ptr,
  output logic [PTR_W-1:0] ptr_nxt
);
  logic             ptr_en;
  logic [PTR_W-1:0] ptr_q;

  always_comb begin
    ptr_en  = push | pop;
    ptr_nxt = ptr_q;
    if (push)     ptr_nxt = ptr_q + PTR_W'(1);
    else if (pop) ptr_nxt = ptr_q - PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_nxt;
  end

  assign ptr = ptr_q;

  AST_PUSH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> ptr_q == PTR_W'($past(ptr_q) + PTR_W'(1))); // R5
  AST_POP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> ptr_q == PTR_W'($past(ptr_q) - PTR_W'(1))); // R8
  AST_PTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop) |=> $stable(ptr_q)); // R9
endmodule

// File: rtl/pcu_addr_calc.sv
module pcu_addr_calc
  import pcu_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LOW_W  = 8
) (
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] tgt,
  output logic [ADDR_W-1:0] pc_inc,
  output logic [ADDR_W-1:0] act_d,
  output logic              act_we,
  output logic              save_we,
  output logic              push,
  output logic              pop
);
  localparam int PAGE_W = ADDR_W - LOW_W;

  always_comb begin
    pc_inc  = pc + ADDR_W'(1);
    act_d   = pc;
    act_we  = 1'b0;
    save_we = 1'b0;
    push    = 1'b0;
    pop     = 1'b0;
    case (pcu_op_e'(op))
      PCU_STEP: begin
        act_d  = pc_inc;
        act_we = 1'b1;
      end
      PCU_CALL: begin
        act_d   = tgt;
        act_we  = 1'b1;
        save_we = 1'b1;
        push    = 1'b1;
      end
      PCU_RET: pop = 1'b1;
      PCU_PJMP: begin
        act_d  = {pc_inc[ADDR_W-1 -: PAGE_W], tgt[LOW_W-1:0]};
        act_we = 1'b1;
      end
      PCU_JMP: begin
        act_d  = tgt;
        act_we = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pcu_regfile.sv
module pcu_regfile #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 4,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_we,
  input  logic [PTR_W-1:0]  act_idx,
  input  logic [ADDR_W-1:0] act_d,
  input  logic              save_we,
  input  logic [PTR_W-1:0]  save_idx,
  input  logic [ADDR_W-1:0] save_d,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_q
);
  logic [DEPTH-1:0][ADDR_W-1:0] slot_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic              act_hit;
    logic              save_hit;
    logic              slot_en;
    logic [ADDR_W-1:0] slot_d;

    always_comb begin
      act_hit  = act_we  && (act_idx  == PTR_W'(i));
      save_hit = save_we && (save_idx == PTR_W'(i));
      slot_en  = act_hit | save_hit;
      slot_d   = act_hit ? act_d : save_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q[i] <= '0;
      else if (slot_en) slot_q[i] <= slot_d;
    end
  end

  assign rd_q = slot_q[rd_idx];

  AST_PORT_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    (act_we && save_we) |-> act_idx != save_idx); // R3
  AST_SAVE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (save_we && act_we) |=> slot_q[$past(save_idx)] == $past(save_d)); // R3
endmodule

// File: rtl/pcu_top.sv
module pcu_top
  import pcu_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LOW_W  = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_i,
  input  logic [ADDR_W-1:0] tgt_i,
  output logic [ADDR_W-1:0] pc_o
);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int PAGE_W = ADDR_W - LOW_W;

  logic              rst_sync_n;
  logic [PTR_W-1:0]  ptr;
  logic [PTR_W-1:0]  ptr_nxt;
  logic [ADDR_W-1:0] pc_inc;
  logic [ADDR_W-1:0] act_d;
  logic              act_we;
  logic              save_we;
  logic              push;
  logic              pop;

  pcu_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pcu_addr_calc #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) i_addr_calc (
    .op      (op_i),
    .pc      (pc_o),
    .tgt     (tgt_i),
    .pc_inc  (pc_inc),
    .act_d   (act_d),
    .act_we  (act_we),
    .save_we (save_we),
    .push    (push),
    .pop     (pop)
  );

  pcu_ptr #(.PTR_W(PTR_W)) i_ptr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .push    (push),
    .pop     (pop),
    .ptr     (ptr),
    .ptr_nxt (ptr_nxt)
  );

  pcu_regfile #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) i_regfile (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .act_we   (act_we),
    .act_idx  (ptr_nxt),
    .act_d    (act_d),
    .save_we  (save_we),
    .save_idx (ptr),
    .save_d   (pc_inc),
    .rd_idx   (ptr),
    .rd_q     (pc_o)
  );

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_sync_n |-> pc_o == '0); // R1
  AST_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_i == 3'd1) |=> pc_o == ADDR_W'($past(pc_o) + ADDR_W'(1))); // R2
  AST_CALL_TARGET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_i == 3'd2) |=> pc_o == $past(tgt_i)); // R3
  AST_PAGE_JUMP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_i == 3'd4) |=> (pc_o[LOW_W-1:0] == $past(tgt_i[LOW_W-1:0])) &&
      (pc_o[ADDR_W-1 -: PAGE_W] == $past(pc_inc[ADDR_W-1 -: PAGE_W]))); // R6
  AST_FULL_JUMP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_i == 3'd5) |=> pc_o == $past(tgt_i)); // R7
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_i == 3'd0 || op_i == 3'd6 || op_i == 3'd7) |=> $stable(pc_o)); // R9
endmodule

// File: tb/test_pcu_top.sv
`timescale 1ns/1ps
module test_pcu_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op_i;
  logic [11:0] tgt_i;
  logic [11:0] pc_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [11:0] m_slot [4];
  logic [1:0]  m_ptr;

  always #5 clk = ~clk;

  pcu_top i_pcu_top (
    .clk   (clk),
    .rst_n (rst_n),
    .op_i  (op_i),
    .tgt_i (tgt_i),
    .pc_o  (pc_o)
  );

  task automatic check(input logic [11:0] exp, input string req);
    n_chk++;
    if (pc_o !== exp) begin
      n_fail++;
      $display("FAIL %s: pc actual %03h expected %03h", req, pc_o, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [11:0] tgt, input string req);
    logic [11:0] pc_m;
    logic [11:0] inc_m;
    @(negedge clk);
    op_i  = op;
    tgt_i = tgt;
    @(posedge clk);
    #2;
    pc_m  = m_slot[m_ptr];
    inc_m = pc_m + 12'd1;
    case (op)
      3'd1: m_slot[m_ptr] = inc_m;
      3'd2: begin
        m_slot[m_ptr] = inc_m;
        m_ptr = m_ptr + 2'd1;
        m_slot[m_ptr] = tgt;
      end
      3'd3: m_ptr = m_ptr - 2'd1;
      3'd4: m_slot[m_ptr] = {inc_m[11:8], tgt[7:0]};
      3'd5: m_slot[m_ptr] = tgt;
      default: ;
    endcase
    check(m_slot[m_ptr], req);
    op_i = 3'd0;
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run actual hung expected done");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    op_i  = 3'd0;
    tgt_i = 12'h000;
    for (int i = 0; i < 4; i++) m_slot[i] = 12'h000;
    m_ptr = 2'd0;
    repeat (3) @(negedge clk);
    check(12'h000, "R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(12'h000, "R1 after release");
    do_op(3'd3, 12'h000, "R1 R8 return from reset ring");
    do_op(3'd2, 12'h000, "R1 R3 rebalance");

    // R2: stepping across the top of the address space
    do_op(3'd5, 12'hFF0, "R7 jump");
    for (int i = 0; i < 20; i++) do_op(3'd1, 12'h000, "R2 step");

    // R6: page jumps from the last byte and from mid-page, every page
    for (int p = 0; p < 16; p++) begin
      do_op(3'd5, {p[3:0], 8'hFF}, "R7 jump to page end");
      do_op(3'd4, 12'(p * 37 + 11), "R6 page jump from byte FF");
      do_op(3'd5, {p[3:0], 8'h40}, "R7 jump mid-page");
      do_op(3'd4, 12'(p * 53 + 5), "R6 page jump mid-page");
    end

    // R3/R4: three nested levels
    do_op(3'd5, 12'h123, "R7 jump");
    do_op(3'd2, 12'h456, "R3 call level 1");
    do_op(3'd1, 12'h000, "R2 step");
    do_op(3'd2, 12'hABC, "R3 call level 2");
    do_op(3'd2, 12'hFFF, "R3 call level 3");
    do_op(3'd3, 12'h000, "R4 return level 3");
    do_op(3'd3, 12'h000, "R4 return level 2");
    do_op(3'd3, 12'h000, "R4 return level 1");
    check(12'h124, "R4 first return address");

    // R5/R8: fourth call overwrites the oldest slot, then over-pop
    do_op(3'd5, 12'h300, "R7 jump");
    do_op(3'd2, 12'h510, "R5 call 1");
    do_op(3'd2, 12'h620, "R5 call 2");
    do_op(3'd2, 12'h730, "R5 call 3");
    do_op(3'd2, 12'h840, "R5 call 4");
    do_op(3'd3, 12'h000, "R5 return 4");
    do_op(3'd3, 12'h000, "R5 return 3");
    do_op(3'd3, 12'h000, "R5 return 2");
    do_op(3'd3, 12'h000, "R5 return 1 overwritten");
    check(12'h840, "R5 overwritten slot holds call 4 target");
    do_op(3'd3, 12'h000, "R8 over-pop wraps");
    check(12'h731, "R8 wrapped slot");

    // R9: unused codes leave pc, pointer and slots alone
    do_op(3'd2, 12'h9A0, "R3 call before hold");
    do_op(3'd0, 12'hFFF, "R9 code 0");
    do_op(3'd6, 12'h555, "R9 code 6");
    do_op(3'd7, 12'hAAA, "R9 code 7");
    check(12'h9A0, "R9 pc unchanged");
    do_op(3'd3, 12'h000, "R9 saved slot intact");
    check(12'h732, "R9 return address after holds");
    summary();
  end
endmodule